// File: doc/BRIEF.md
# Converter Status Flag Register

This block is the event-status word of an analog converter controller. Five hardware event pulses each set one sticky flag: a regular conversion began, an injected group began, an injected group finished, any group finished, and a converted sample left the threshold window. A flag stays set until software clears it. Software reads and clears the flags through a small register port that has an address, write enable, write data, read enable and read data.

Software clears a flag by writing 0 to its bit. Writing 1 to a bit leaves that flag alone. The end-of-conversion flag also clears when a separate strobe reports a read of the conversion data register. If an event and a clear reach the same flag in the same cycle, the event wins, so no event is lost. The word sits at offset 0x00. Its upper 27 bits are reserved and always read as zero.

Top module: `conv_status_reg`

## Requirements
- R1: After reset every flag is 0, so a read of offset 0x00 returns 0x00000000.
- R2: A one-cycle pulse on an event input sets its flag at the next rising edge. The bit positions are: bit 0 on `ev_window`, bit 1 on `ev_grp_end`, bit 2 on `ev_inj_end`, bit 3 on `ev_inj_start`, bit 4 on `ev_reg_start`. The engine pulses `ev_grp_end` at the end of every group, regular or injected. It pulses `ev_inj_end` only once all injected channels are done.
- R3: A set flag keeps its value for any number of cycles until a clear reaches it.
- R4: A write to offset 0x00 clears every flag whose bit in bits 4:0 of the write data is 0 and leaves every flag whose bit is 1 unchanged. The new value is visible after the rising edge of the write cycle. A write to any other offset changes no flag.
- R5: Bits 31:5 always read as 0. Write data in those bits has no effect on any flag.
- R6: A pulse on `data_rd_strobe` clears bit 1 (end of conversion) and no other flag.
- R7: When an event pulse and a clear (by write or by data strobe) hit the same flag in the same cycle, the flag ends up set.
- R8: `bus_rd_data` carries the flag word when `bus_rd_en` is high and the address is 0x00. Otherwise it is 0.
- R9: Reading the status word does not change any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr_en | input | 1 | Write qualifier for the current cycle |
| bus_wr_data | input | DATA_W | Write data; 0 in a flag bit clears that flag |
| bus_rd_en | input | 1 | Read qualifier |
| bus_rd_data | output | DATA_W | Read data, combinational from address and read enable |
| data_rd_strobe | input | 1 | Pulse when software reads the conversion data register |
| ev_reg_start | input | 1 | Regular conversion began |
| ev_inj_start | input | 1 | Injected group conversion began |
| ev_inj_end | input | 1 | All channels of the injected group converted |
| ev_grp_end | input | 1 | A regular or injected group finished |
| ev_window | input | 1 | Converted value fell outside the threshold window |

## Verification
The bench goes through every combination of set flags against every 5-bit clear mask. This would expose a design that clears on written ones or that leaks reserved write bits into the flags. For each flag, it raises an event in the same cycle as a write clear and as a data-strobe clear. A design that lets the clear win would drop that event. It also writes to offsets other than 0x00 and repeats status reads. A decoder that ignores the upper address bits, or a read with a side effect, would show up as flags that disappear.

// File: rtl/conv_status_pkg.sv
package conv_status_pkg;
  localparam int unsigned FLAG_CNT = 5;

  typedef enum int unsigned {
    FL_WINDOW    = 0,
    FL_ANY_END   = 1,
    FL_INJ_END   = 2,
    FL_INJ_START = 3,
    FL_REG_START = 4
  } flag_idx_e;

  typedef logic [FLAG_CNT-1:0] flag_vec_t;
endpackage

// File: rtl/csr_reset_sync.sv
module csr_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/csr_bus_decode.sv
module csr_bus_decode
  import conv_status_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REG_OFFSET = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  flag_vec_t         flags,
  output flag_vec_t         clr_mask,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);
  localparam int unsigned RSV_W = DATA_W - FLAG_CNT;

  logic sel;
  assign sel = (addr == OFFS);

  // R4/R5: only the low flag bits of a decoded write form the clear mask
  always_comb begin
    clr_mask = '0;
    if (wr_en && sel) clr_mask = ~wr_data[FLAG_CNT-1:0];
  end

  // R8: read data is zero unless a qualified read hits this offset
  always_comb begin
    rd_data = '0;
    if (rd_en && sel) rd_data = {{RSV_W{1'b0}}, flags};
  end
endmodule

// File: rtl/csr_flag_cell.sv
module csr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr_i) q_nxt = 1'b0;
    if (set_i) q_nxt = 1'b1;   // R7: event wins
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> (q == $past(q)));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q);
endmodule

// File: rtl/conv_status_reg.sv
module conv_status_reg
  import conv_status_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REG_OFFSET = 0,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rd_data,
  input  logic              data_rd_strobe,
  input  logic              ev_reg_start,
  input  logic              ev_inj_start,
  input  logic              ev_inj_end,
  input  logic              ev_grp_end,
  input  logic              ev_window
);
  logic      rst_sync_n;
  flag_vec_t flags;
  flag_vec_t set_vec;
  flag_vec_t wr_clr;
  flag_vec_t clr_vec;

  csr_reset_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  csr_bus_decode #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .REG_OFFSET (REG_OFFSET)
  ) u_dec (
    .addr     (bus_addr),
    .wr_en    (bus_wr_en),
    .wr_data  (bus_wr_data),
    .rd_en    (bus_rd_en),
    .flags    (flags),
    .clr_mask (wr_clr),
    .rd_data  (bus_rd_data)
  );

  // R2: event to bit mapping
  always_comb begin
    set_vec               = '0;
    set_vec[FL_WINDOW]    = ev_window;
    set_vec[FL_ANY_END]   = ev_grp_end;
    set_vec[FL_INJ_END]   = ev_inj_end;
    set_vec[FL_INJ_START] = ev_inj_start;
    set_vec[FL_REG_START] = ev_reg_start;
  end

  genvar gi;
  generate
    for (gi = 0; gi < FLAG_CNT; gi++) begin : g_flag
      if (gi == int'(FL_ANY_END)) begin : g_eoc
        // R6: data register read also clears end of conversion
        assign clr_vec[gi] = wr_clr[gi] | data_rd_strobe;
      end else begin : g_plain
        assign clr_vec[gi] = wr_clr[gi];
      end
      csr_flag_cell u_cell (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .set_i (set_vec[gi]),
        .clr_i (clr_vec[gi]),
        .q     (flags[gi])
      );
    end
  endgenerate

  p_strobe_eoc_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (data_rd_strobe && !ev_grp_end) |=> !flags[FL_ANY_END]);
  p_read_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd_en && !bus_wr_en && !data_rd_strobe && (set_vec == '0)) |=> $stable(flags));
  p_rsv_write_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_en && (bus_wr_data[FLAG_CNT-1:0] == '1) && !data_rd_strobe && (set_vec == '0))
      |=> $stable(flags));
endmodule

// File: tb/conv_status_reg_tb.sv
`timescale 1ns/1ps
module conv_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wr_data;
  logic        bus_rd_en;
  logic [31:0] bus_rd_data;
  logic        data_rd_strobe;
  logic        ev_reg_start, ev_inj_start, ev_inj_end, ev_grp_end, ev_window;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  conv_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
    .data_rd_strobe(data_rd_strobe), .ev_reg_start(ev_reg_start),
    .ev_inj_start(ev_inj_start), .ev_inj_end(ev_inj_end),
    .ev_grp_end(ev_grp_end), .ev_window(ev_window)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one clock cycle of stimulus: events, optional write, optional strobe
  task automatic op(input logic [4:0] ev, input logic wr, input logic [7:0] a,
                    input logic [31:0] wd, input logic stb);
    @(negedge clk);
    {ev_reg_start, ev_inj_start, ev_inj_end, ev_grp_end, ev_window} = ev;
    bus_wr_en = wr; bus_addr = a; bus_wr_data = wd; data_rd_strobe = stb;
    @(negedge clk);
    {ev_reg_start, ev_inj_start, ev_inj_end, ev_grp_end, ev_window} = '0;
    bus_wr_en = 1'b0; bus_addr = 8'h00; bus_wr_data = '0; data_rd_strobe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    #1 v = bus_rd_data;
    #1 bus_rd_en = 1'b0; bus_addr = 8'h00;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wr_en = 0; bus_wr_data = '0; bus_rd_en = 0;
    data_rd_strobe = 0;
    {ev_reg_start, ev_inj_start, ev_inj_end, ev_grp_end, ev_window} = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    rd(8'h00, v); check("R1 reset value", v, 32'h0);

    // R2: each event alone sets its own bit
    for (int i = 0; i < 5; i++) begin
      op(5'(1 << i), 0, 8'h00, 32'h0, 0);
      rd(8'h00, v); check("R2 single event bit", v, 32'(1 << i));
      op(5'h00, 1, 8'h00, 32'h0, 0);
    end

    // R3: sticky across idle cycles
    op(5'h1F, 0, 8'h00, 32'h0, 0);
    repeat (20) @(negedge clk);
    rd(8'h00, v); check("R3 sticky", v, 32'h1F);

    // R4/R5: all patterns against all clear masks, reserved write bits noisy
    for (int p = 0; p < 32; p++) begin
      for (int w = 0; w < 32; w++) begin
        op(5'h00, 1, 8'h00, 32'h0, 0);
        op(5'(p), 0, 8'h00, 32'h0, 0);
        if (w == 0) begin rd(8'h00, v); check("R2 pattern set", v, 32'(p)); end
        op(5'h00, 1, 8'h00, {27'(32'h5A5A5A5 ^ (p * 977 + w)), 5'(w)}, 0);
        rd(8'h00, v); check("R4 R5 write-zero clear", v, 32'(p & w));
      end
    end

    // R4: writes to other offsets ignored
    op(5'h1F, 0, 8'h00, 32'h0, 0);
    for (int a = 1; a < 256; a += 17) begin
      op(5'h00, 1, 8'(a), 32'h0, 0);
      rd(8'h00, v); check("R4 other offset write", v, 32'h1F);
    end

    // R6: data strobe clears only bit 1
    for (int p = 0; p < 32; p++) begin
      op(5'h00, 1, 8'h00, 32'h0, 0);
      op(5'(p), 0, 8'h00, 32'h0, 0);
      op(5'h00, 0, 8'h00, 32'h0, 1);
      rd(8'h00, v); check("R6 strobe clears eoc", v, 32'(p & 5'h1D));
    end

    // R7: event beats simultaneous write clear and strobe clear
    for (int i = 0; i < 5; i++) begin
      op(5'h1F, 0, 8'h00, 32'h0, 0);
      op(5'(1 << i), 1, 8'h00, 32'h0, 1);
      rd(8'h00, v); check("R7 set wins", v, 32'(1 << i));
    end
    op(5'h00, 1, 8'h00, 32'h0, 0);
    op(5'h00, 0, 8'h00, 32'h0, 0);
    op(5'h02, 0, 8'h00, 32'h0, 1);
    rd(8'h00, v); check("R7 eoc set over strobe", v, 32'h2);

    // R8/R9: read gating and no read side effect
    op(5'h15, 1, 8'h00, 32'h0, 0);
    for (int k = 0; k < 4; k++) begin
      rd(8'h00, v); check("R9 read no side effect", v, 32'h15);
    end
    rd(8'h04, v); check("R8 other offset reads zero", v, 32'h0);
    @(negedge clk); #1 check("R8 no read enable zero", bus_rd_data, 32'h0);

    // R1: reset mid-run clears all
    op(5'h1F, 0, 8'h00, 32'h0, 0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'h00, v); check("R1 reset clears", v, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule